// File: doc/BRIEF.md
# I2C Register-File Slave

This block sits on a two-wire serial control bus as a target device and holds a bank of 256 byte-wide control registers. It runs entirely on the system clock. Both bus lines pass through a synchroniser and a short majority-free glitch filter, and START and STOP conditions are then detected. When the seven-bit device address matches, the block acknowledges. On a write it takes the next byte as the register pointer and stores every following byte at the pointer, which then advances. On a read it shifts out the register at the pointer and advances the pointer after each byte.

A read has no pointer phase of its own. It continues from wherever the last write left the pointer. To read a chosen register, a master first sends a write that carries only the pointer byte, then issues a read. Every stored byte also appears for one cycle on a write strobe, so neighbouring logic can follow register changes. The block has no data stream with flow control: the bus master sets the pace, and the strobe is a plain one-cycle pulse with no back-pressure.

Top module: `i2c_regfile_slave`

## Requirements
- R1: After reset the block does not pull SDA low and the write strobe is low.
- R2: A first byte whose upper seven bits are 1000000 is acknowledged by pulling SDA low during the ninth SCL pulse; its LSB selects the direction (0 = write, 1 = read).
- R3: If the address does not match, the block does not acknowledge, does not drive SDA and writes nothing until the next START or STOP.
- R4: In a write, the byte after the address loads the pointer and is acknowledged without a register write; each later byte (MSB first) is acknowledged and stored, with wr_addr equal to the pointer and wr_data equal to the byte.
- R5: The pointer advances by one after each byte stored and wraps from 0xFF to 0x00.
- R6: A read returns, MSB first, the register at the pointer left by the previous write, and then the following registers, one per byte.
- R7: After the master answers a read byte with NACK (SDA high in the ninth pulse), the block releases SDA and drives nothing more until the next START or STOP.
- R8: A repeated START in mid-transfer restarts address reception and keeps the current pointer.
- R9: An SCL pulse lasting fewer than three system-clock cycles is ignored.
- R10: The SDA drive changes only while the filtered SCL is low.
- R11: The write strobe is high for exactly one cycle per stored byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Serial clock line as seen on the bus |
| sda_in | input | 1 | Serial data line as seen on the bus |
| sda_drive_low | output | 1 | When high, the open-drain SDA pad pulls low |
| wr_stb | output | 1 | One-cycle pulse for each register written |
| wr_addr | output | 8 | Register index of the current write |
| wr_data | output | 8 | Byte written in the current write |

## Verification
The register store and the acknowledge drive both happen on the same falling SCL edge that closes a data byte, so the strobe and the SDA pull-down rise in the same cycle. Back-to-back writes across the 0xFF boundary, and a repeated START that follows a store, push this shared edge hardest. The bench checks the captured strobe address and data against its own register model, confirms an ACK was seen for each byte, and a checker requires that every strobe coincides with an active acknowledge and that successive strobes within one transfer step the address by one.

// File: rtl/i2c_rf_pkg.sv
package i2c_rf_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_SUB,
    ST_WDATA,
    ST_ACK,
    ST_TX,
    ST_TX_ACK,
    ST_IGNORE
  } ctrl_state_t;

  typedef enum logic [1:0] {
    NX_SUB,
    NX_WDATA,
    NX_TX
  } after_ack_t;
endpackage

// File: rtl/i2c_line_filter.sv
module i2c_line_filter #(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN    = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_in,
  output logic line_out
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic [FILT_LEN-1:0]    hist_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q   <= '1;
      hist_q   <= '1;
      line_out <= 1'b1;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], line_in};
      hist_q <= {hist_q[FILT_LEN-2:0], sync_q[SYNC_STAGES-1]};
      if (&hist_q)
        line_out <= 1'b1;
      else if (~|hist_q)
        line_out <= 1'b0;
    end
  end
endmodule

// File: rtl/i2c_bus_events.sv
module i2c_bus_events (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_f,
  input  logic sda_f,
  output logic start_evt,
  output logic stop_evt,
  output logic scl_rise,
  output logic scl_fall
);
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_f;
      sda_q <= sda_f;
    end
  end

  assign start_evt = scl_f & scl_q & sda_q & ~sda_f;
  assign stop_evt  = scl_f & scl_q & ~sda_q & sda_f;
  assign scl_rise  = scl_f & ~scl_q;
  assign scl_fall  = ~scl_f & scl_q;
endmodule

// File: rtl/i2c_reg_array.sv
module i2c_reg_array #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (we) begin
      mem_q[waddr] <= wdata;
    end
  end

  assign rdata = mem_q[raddr];
endmodule

// File: rtl/i2c_slave_ctrl.sv
module i2c_slave_ctrl
  import i2c_rf_pkg::*;
#(
  parameter int         AW         = 8,
  parameter int         DW         = 8,
  parameter logic [6:0] SLAVE_ADDR = 7'h40
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_evt,
  input  logic          stop_evt,
  input  logic          scl_rise,
  input  logic          scl_fall,
  input  logic          sda_f,
  input  logic [DW-1:0] rd_data,
  output logic [AW-1:0] ptr,
  output logic          sda_oe,
  output logic          wr_stb,
  output logic [AW-1:0] wr_addr,
  output logic [DW-1:0] wr_data,
  output ctrl_state_t   state_o
);
  localparam int             CNT_W    = $clog2(DW + 1);
  localparam logic [CNT_W-1:0] BYTE_END = CNT_W'(DW);

  ctrl_state_t      state;
  after_ack_t       nxt;
  logic [DW-1:0]    shreg;
  logic [CNT_W-1:0] bit_cnt;

  assign state_o = state;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      nxt     <= NX_SUB;
      shreg   <= '0;
      bit_cnt <= '0;
      ptr     <= '0;
      sda_oe  <= 1'b0;
      wr_stb  <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
    end else begin
      wr_stb <= 1'b0;
      if (start_evt) begin
        state   <= ST_ADDR;
        bit_cnt <= '0;
        sda_oe  <= 1'b0;
      end else if (stop_evt) begin
        state  <= ST_IDLE;
        sda_oe <= 1'b0;
      end else begin
        case (state)
          ST_ADDR, ST_SUB, ST_WDATA: begin
            if (scl_rise && bit_cnt != BYTE_END) begin
              shreg   <= {shreg[DW-2:0], sda_f};
              bit_cnt <= bit_cnt + 1'b1;
            end else if (scl_fall && bit_cnt == BYTE_END) begin
              bit_cnt <= '0;
              case (state)
                ST_ADDR: begin
                  if (shreg[DW-1:1] == SLAVE_ADDR) begin
                    sda_oe <= 1'b1;
                    state  <= ST_ACK;
                    nxt    <= shreg[0] ? NX_TX : NX_SUB;
                  end else begin
                    state <= ST_IGNORE;
                  end
                end
                ST_SUB: begin
                  ptr    <= shreg;
                  sda_oe <= 1'b1;
                  state  <= ST_ACK;
                  nxt    <= NX_WDATA;
                end
                default: begin
                  wr_stb  <= 1'b1;
                  wr_addr <= ptr;
                  wr_data <= shreg;
                  ptr     <= ptr + 1'b1;
                  sda_oe  <= 1'b1;
                  state   <= ST_ACK;
                  nxt     <= NX_WDATA;
                end
              endcase
            end
          end
          ST_ACK: begin
            if (scl_fall) begin
              case (nxt)
                NX_SUB: begin
                  sda_oe <= 1'b0;
                  state  <= ST_SUB;
                end
                NX_WDATA: begin
                  sda_oe <= 1'b0;
                  state  <= ST_WDATA;
                end
                default: begin
                  sda_oe  <= ~rd_data[DW-1];
                  shreg   <= {rd_data[DW-2:0], 1'b0};
                  ptr     <= ptr + 1'b1;
                  bit_cnt <= CNT_W'(1);
                  state   <= ST_TX;
                end
              endcase
            end
          end
          ST_TX: begin
            if (scl_fall) begin
              if (bit_cnt == BYTE_END) begin
                sda_oe <= 1'b0;
                state  <= ST_TX_ACK;
              end else begin
                sda_oe  <= ~shreg[DW-1];
                shreg   <= {shreg[DW-2:0], 1'b0};
                bit_cnt <= bit_cnt + 1'b1;
              end
            end
          end
          ST_TX_ACK: begin
            if (scl_rise) begin
              if (sda_f) begin
                state <= ST_IGNORE;
              end else begin
                state <= ST_ACK;
                nxt   <= NX_TX;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/i2c_regfile_slave.sv
module i2c_regfile_slave
  import i2c_rf_pkg::*;
#(
  parameter logic [6:0] SLAVE_ADDR  = 7'h40,
  parameter int         REG_AW      = 8,
  parameter int         DATA_W      = 8,
  parameter int         SYNC_STAGES = 2,
  parameter int         FILT_LEN    = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_in,
  input  logic              sda_in,
  output logic              sda_drive_low,
  output logic              wr_stb,
  output logic [REG_AW-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data
);
  localparam int N_LINES = 2;

  logic [N_LINES-1:0] raw_lines, filt_lines;
  logic scl_f, sda_f;
  logic start_evt, stop_evt, scl_rise, scl_fall;
  logic [REG_AW-1:0] ptr;
  logic [DATA_W-1:0] rd_data;
  ctrl_state_t ctrl_state;

  assign raw_lines = {scl_in, sda_in};

  for (genvar g = 0; g < N_LINES; g++) begin : g_line
    i2c_line_filter #(
      .SYNC_STAGES(SYNC_STAGES),
      .FILT_LEN   (FILT_LEN)
    ) u_filt (
      .clk     (clk),
      .rst_n   (rst_n),
      .line_in (raw_lines[g]),
      .line_out(filt_lines[g])
    );
  end

  assign scl_f = filt_lines[1];
  assign sda_f = filt_lines[0];

  i2c_bus_events u_events (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_f    (scl_f),
    .sda_f    (sda_f),
    .start_evt(start_evt),
    .stop_evt (stop_evt),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall)
  );

  i2c_slave_ctrl #(
    .AW        (REG_AW),
    .DW        (DATA_W),
    .SLAVE_ADDR(SLAVE_ADDR)
  ) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_evt(start_evt),
    .stop_evt (stop_evt),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .sda_f    (sda_f),
    .rd_data  (rd_data),
    .ptr      (ptr),
    .sda_oe   (sda_drive_low),
    .wr_stb   (wr_stb),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .state_o  (ctrl_state)
  );

  i2c_reg_array #(
    .AW(REG_AW),
    .DW(DATA_W)
  ) u_regs (
    .clk  (clk),
    .rst_n(rst_n),
    .we   (wr_stb),
    .waddr(wr_addr),
    .wdata(wr_data),
    .raddr(ptr),
    .rdata(rd_data)
  );
endmodule

// File: rtl/i2c_regfile_slave_checker.sv
module i2c_regfile_slave_checker
  import i2c_rf_pkg::*;
#(
  parameter int AW = 8
) (
  input logic        clk,
  input logic        rst_n,
  input logic        scl_f,
  input logic        start_evt,
  input logic        sda_drive_low,
  input logic        wr_stb,
  input logic [AW-1:0] wr_addr,
  input ctrl_state_t ctrl_state
);
  logic [AW-1:0] last_addr;
  logic          seq_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_addr <= '0;
      seq_valid <= 1'b0;
    end else if (start_evt) begin
      seq_valid <= 1'b0;
    end else if (wr_stb) begin
      last_addr <= wr_addr;
      seq_valid <= 1'b1;
    end
  end

  assert_strobe_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |=> !wr_stb);

  assert_drive_scl_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_drive_low != $past(sda_drive_low)) |-> !scl_f);

  assert_ignore_silent_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_state == ST_IGNORE) |-> !sda_drive_low);

  assert_store_acked_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |-> sda_drive_low);

  assert_addr_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && seq_valid) |-> (wr_addr == AW'(last_addr + 1'b1)));
endmodule

bind i2c_regfile_slave i2c_regfile_slave_checker #(.AW(REG_AW)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .scl_f        (scl_f),
  .start_evt    (start_evt),
  .sda_drive_low(sda_drive_low),
  .wr_stb       (wr_stb),
  .wr_addr      (wr_addr),
  .ctrl_state   (ctrl_state)
);

// File: tb/tb_i2c_regfile_slave.sv
module tb_i2c_regfile_slave;
  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic sda_drive_low, wr_stb;
  logic [7:0] wr_addr, wr_data;
  wire sda_line = sda_m & ~sda_drive_low;

  always #(CLK_PERIOD / 2) clk = ~clk;

  i2c_regfile_slave dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .scl_in       (scl_m),
    .sda_in       (sda_line),
    .sda_drive_low(sda_drive_low),
    .wr_stb       (wr_stb),
    .wr_addr      (wr_addr),
    .wr_data      (wr_data)
  );

  int checks = 0, fails = 0;
  logic [7:0] exp_mem [256];
  logic [7:0] exp_ptr;
  logic [7:0] cap_a [64];
  logic [7:0] cap_d [64];
  int cap_n = 0, dbl_cnt = 0, edge_viol = 0, drv_cnt = 0;
  logic prev_stb = 1'b0, prev_drv = 1'b0;
  bit done = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (wr_stb) begin
        if (cap_n < 64) begin
          cap_a[cap_n] = wr_addr;
          cap_d[cap_n] = wr_data;
        end
        cap_n++;
        if (prev_stb) dbl_cnt++;
      end
      if (sda_drive_low != prev_drv && scl_m) edge_viol++;
      if (sda_drive_low) drv_cnt++;
    end
    prev_stb = wr_stb;
    prev_drv = sda_drive_low;
  end

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_n(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bit(bit b, bit glitch, output bit rb);
    wait_n(2);
    sda_m = b;
    if (glitch) begin
      wait_n(4);
      scl_m = 1'b1;
      wait_n(2);
      scl_m = 1'b0;
      wait_n(HALF - 8);
    end else begin
      wait_n(HALF - 2);
    end
    scl_m = 1'b1;
    wait_n(HALF / 2);
    rb = sda_line;
    wait_n(HALF / 2);
    scl_m = 1'b0;
  endtask

  task automatic write_byte(logic [7:0] v, bit glitch, output bit ack);
    bit r;
    for (int i = 7; i >= 0; i--) send_bit(v[i], glitch && (i == 3), r);
    send_bit(1'b1, 1'b0, r);
    ack = !r;
  endtask

  task automatic read_byte(bit nack, output logic [7:0] v);
    bit r;
    for (int i = 7; i >= 0; i--) begin
      send_bit(1'b1, 1'b0, r);
      v[i] = r;
    end
    send_bit(nack, 1'b0, r);
  endtask

  task automatic start_c();
    wait_n(2);
    sda_m = 1'b1;
    wait_n(HALF);
    scl_m = 1'b1;
    wait_n(HALF);
    sda_m = 1'b0;
    wait_n(HALF);
    scl_m = 1'b0;
  endtask

  task automatic stop_c();
    wait_n(2);
    sda_m = 1'b0;
    wait_n(HALF);
    scl_m = 1'b1;
    wait_n(HALF);
    sda_m = 1'b1;
    wait_n(HALF);
  endtask

  // pointer byte then n data bytes; check ACKs and strobes
  task automatic do_write(logic [7:0] sub, int n);
    bit ack;
    logic [7:0] d;
    logic [7:0] ea [16];
    logic [7:0] ed [16];
    start_c();
    write_byte(8'h80, 1'b0, ack);
    chk(ack, "R2 write address ack", ack, 1);
    cap_n = 0;
    write_byte(sub, 1'b0, ack);
    chk(ack, "R4 pointer byte ack", ack, 1);
    exp_ptr = sub;
    for (int k = 0; k < n; k++) begin
      d = 8'($urandom);
      write_byte(d, 1'b0, ack);
      chk(ack, "R4 data byte ack", ack, 1);
      ea[k] = exp_ptr;
      ed[k] = d;
      exp_mem[exp_ptr] = d;
      exp_ptr = exp_ptr + 8'd1;
    end
    stop_c();
    chk(cap_n == n, "R4 strobe count", cap_n, n);
    for (int k = 0; k < n && k < cap_n; k++) begin
      chk(cap_a[k] == ea[k], "R5 strobe address", cap_a[k], ea[k]);
      chk(cap_d[k] == ed[k], "R4 strobe data", cap_d[k], ed[k]);
    end
  endtask

  task automatic do_read(int n, int extra_bits);
    bit ack, r;
    logic [7:0] v;
    int d0;
    start_c();
    write_byte(8'h81, 1'b0, ack);
    chk(ack, "R2 read address ack", ack, 1);
    for (int k = 0; k < n; k++) begin
      read_byte(k == n - 1, v);
      chk(v == exp_mem[exp_ptr], "R6 read data", v, exp_mem[exp_ptr]);
      exp_ptr = exp_ptr + 8'd1;
    end
    d0 = drv_cnt;
    for (int k = 0; k < extra_bits; k++) send_bit(1'b1, 1'b0, r);
    if (extra_bits > 0) chk(drv_cnt == d0, "R7 no drive after NACK", drv_cnt - d0, 0);
    stop_c();
  endtask

  initial begin
    bit ack;
    int d0, n;
    logic [7:0] d, v, sub;
    void'($urandom(32'd1357));
    for (int i = 0; i < 256; i++) exp_mem[i] = 8'h00;
    exp_ptr = 8'h00;

    wait_n(5);
    chk(sda_drive_low == 1'b0, "R1 SDA released in reset", sda_drive_low, 0);
    chk(wr_stb == 1'b0, "R1 strobe low in reset", wr_stb, 0);
    rst_n = 1'b1;
    wait_n(20);
    chk(sda_drive_low == 1'b0, "R1 SDA released after reset", sda_drive_low, 0);

    do_write(8'h20, 7);
    do_write(8'h20, 0);
    do_read(6, 9);
    do_read(1, 0);

    // non-matching address is ignored
    d0 = drv_cnt;
    start_c();
    cap_n = 0;
    write_byte(8'h84, 1'b0, ack);
    chk(!ack, "R3 no ack on foreign address", ack, 0);
    write_byte(8'h05, 1'b0, ack);
    chk(!ack, "R3 no ack on following byte", ack, 0);
    write_byte(8'h77, 1'b0, ack);
    chk(!ack, "R3 no ack on second byte", ack, 0);
    stop_c();
    chk(cap_n == 0, "R3 nothing written", cap_n, 0);
    chk(drv_cnt == d0, "R3 SDA never driven", drv_cnt - d0, 0);
    do_read(1, 0);

    // pointer wrap
    do_write(8'hFE, 4);

    // repeated START keeps pointer
    do_write(8'h51, 2);
    start_c();
    write_byte(8'h80, 1'b0, ack);
    write_byte(8'h50, 1'b0, ack);
    d = 8'($urandom);
    cap_n = 0;
    write_byte(d, 1'b0, ack);
    chk(ack, "R8 data ack before restart", ack, 1);
    exp_mem[8'h50] = d;
    exp_ptr = 8'h51;
    start_c();
    write_byte(8'h81, 1'b0, ack);
    chk(ack, "R8 address ack after repeated start", ack, 1);
    for (int k = 0; k < 2; k++) begin
      read_byte(k == 1, v);
      chk(v == exp_mem[exp_ptr], "R8 read continues from pointer", v, exp_mem[exp_ptr]);
      exp_ptr = exp_ptr + 8'd1;
    end
    stop_c();
    chk(cap_n == 1 && cap_a[0] == 8'h50, "R8 store before restart", cap_a[0], 8'h50);

    // short SCL glitches
    start_c();
    write_byte(8'h80, 1'b1, ack);
    chk(ack, "R9 address ack with glitch", ack, 1);
    write_byte(8'h30, 1'b1, ack);
    chk(ack, "R9 pointer ack with glitch", ack, 1);
    cap_n = 0;
    d = 8'($urandom);
    write_byte(d, 1'b1, ack);
    chk(ack, "R9 data ack with glitch", ack, 1);
    stop_c();
    exp_mem[8'h30] = d;
    chk(cap_n == 1, "R9 single store", cap_n, 1);
    chk(cap_a[0] == 8'h30, "R9 store address", cap_a[0], 8'h30);
    chk(cap_d[0] == d, "R9 store data", cap_d[0], d);

    // random traffic
    for (int t = 0; t < 10; t++) begin
      sub = 8'($urandom);
      n = 1 + int'($urandom % 4);
      do_write(sub, n);
      do_write(sub, 0);
      do_read(n, 0);
    end

    chk(dbl_cnt == 0, "R11 strobe one cycle", dbl_cnt, 0);
    chk(edge_viol == 0, "R10 SDA changes only with SCL low", edge_viol, 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule